// File: doc/BRIEF.md
# Four-Function Shared-Adder ALU

This block is a purely combinational arithmetic and logic unit working on two unsigned or two's-complement operands of a parameterised width (8 bits by default). A two-bit function code picks one of four operations: sum, difference, bitwise AND, or bitwise OR. The result is a plain data word with no flags alongside it.

Addition and subtraction share one ripple-carry adder. The difference is formed by adding the first operand to the bitwise complement of the second, with a carry-in of one. The low function bit does three jobs at once. It steers the second operand through an invert-or-pass stage, it is the adder's carry-in, and it chooses OR over AND in the logic path. The high function bit picks the logic path over the adder for the output.

The adder drops its final carry, so every arithmetic result wraps modulo 2^W. The block has no clock and no state, and it sits directly in a surrounding datapath. There is no handshake at its edge: the result follows the operands and the function code within the same evaluation.

Top module: `alu4_top`

## Requirements
- R1: With {sel_logic,sel_alt} = 2'b00, result equals (opnd_a + opnd_b) mod 2^W.
- R2: With {sel_logic,sel_alt} = 2'b01, result equals (opnd_a − opnd_b) mod 2^W, formed as opnd_a + ~opnd_b + 1. For example, 126 − 127 gives 8'hFF.
- R3: With {sel_logic,sel_alt} = 2'b10, result equals opnd_a & opnd_b, bit by bit.
- R4: With {sel_logic,sel_alt} = 2'b11, result equals opnd_a | opnd_b, bit by bit.
- R5: The carry out of the top adder bit is discarded. For example, 127 + 127 gives 254 and 255 + 1 gives 0, and no other output carries the lost bit.
- R6: When every input is 0 or 1, every bit of result is 0 or 1.
- R7: With A=146 and B=58, the codes 00, 01, 10 and 11 give 204, 88, 8'b00010010 and 8'b10111010.
- R8: The result depends only on the present inputs. The same inputs give the same result whatever inputs came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W | First operand (minuend for subtraction) |
| opnd_b | input | W | Second operand (subtrahend for subtraction) |
| sel_logic | input | 1 | 0 selects the adder output, 1 selects the logic output |
| sel_alt | input | 1 | Adder: 0 add, 1 subtract (also the carry-in). Logic: 0 AND, 1 OR |
| result | output | W | Selected result, arithmetic wrapped modulo 2^W |

## Verification
The hardest case to reach is a carry or borrow that travels the whole length of the ripple chain. Examples are 255 + 1, 0 − 1, and subtracting an operand from itself, where the inverted second operand plus the carry-in ripples through every bit. Random operands seldom line up that way. The stimulus therefore sweeps every operand pair under every function code, and adds directed all-ones, all-zero and equal-operand vectors plus a seeded random run that revisits inputs after unrelated history.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_AND = 2'b10,
    FN_OR  = 2'b11
  } alu4_fn_e;
endpackage

// File: rtl/alu4_bcond.sv
// Invert-or-pass stage for the second adder operand.
module alu4_bcond #(
  parameter int W = 8
) (
  input  logic [W-1:0] b_in,
  input  logic         invert,
  output logic [W-1:0] b_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_out[i] = invert ? ~b_in[i] : b_in[i];
  end
endmodule

// File: rtl/alu4_ripple.sv
// Ripple-carry adder; the carry out of the top bit is not formed.
module alu4_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W-1:0] carry;
  assign carry[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i] = a[i] ^ b[i] ^ carry[i];
    if (i < W - 1) begin : g_cy
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  end
endmodule

// File: rtl/alu4_logic.sv
// Bitwise AND / OR pair with a per-bit select.
module alu4_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         pick_or,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic and_b, or_b;
    assign and_b = a[i] & b[i];
    assign or_b  = a[i] | b[i];
    assign y[i]  = pick_or ? or_b : and_b;
  end
endmodule

// File: rtl/alu4_omux.sv
// Output source select: adder or logic path.
module alu4_omux #(
  parameter int W = 8
) (
  input  logic [W-1:0] arith,
  input  logic [W-1:0] logic_r,
  input  logic         take_logic,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = take_logic ? logic_r[i] : arith[i];
  end
endmodule

// File: rtl/alu4_top.sv
module alu4_top
  import alu4_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         sel_logic,
  input  logic         sel_alt,
  output logic [W-1:0] result
);
  alu4_fn_e     fn;
  logic [W-1:0] b_cond, sum_w, log_w;

  assign fn = alu4_fn_e'({sel_logic, sel_alt});

  // sel_alt: operand invert, carry-in and AND/OR choice (R2, R3, R4)
  alu4_bcond #(.W(W)) u_bcond (
    .b_in(opnd_b), .invert(fn == FN_SUB || fn == FN_OR), .b_out(b_cond)
  );
  alu4_ripple #(.W(W)) u_add (
    .a(opnd_a), .b(b_cond), .cin(sel_alt), .sum(sum_w)
  );
  alu4_logic #(.W(W)) u_log (
    .a(opnd_a), .b(opnd_b), .pick_or(sel_alt), .y(log_w)
  );
  alu4_omux #(.W(W)) u_omux (
    .arith(sum_w), .logic_r(log_w), .take_logic(sel_logic), .y(result)
  );
endmodule

// File: rtl/alu4_chk.sv
module alu4_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         sel_logic,
  input logic         sel_alt,
  input logic [W-1:0] result
);
  logic         known_in;
  logic [W-1:0] m_add, m_sub;

  assign known_in = !$isunknown({opnd_a, opnd_b, sel_logic, sel_alt});
  assign m_add    = opnd_a + opnd_b;
  assign m_sub    = opnd_a - opnd_b;

  always_comb begin
    if (known_in) begin
      assert_known_R6: assert (!$isunknown(result))
        else $error("result has unknown bits");
      if (!sel_logic && !sel_alt)
        assert_add_R1: assert (result == m_add) else $error("add mismatch");
      if (!sel_logic && sel_alt)
        assert_sub_R2: assert (result == m_sub) else $error("sub mismatch");
      if (sel_logic && !sel_alt)
        assert_and_R3: assert (result == (opnd_a & opnd_b)) else $error("and mismatch");
      if (sel_logic && sel_alt)
        assert_or_R4: assert (result == (opnd_a | opnd_b)) else $error("or mismatch");
    end
  end
endmodule

bind alu4_top alu4_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu4_top.sv
`timescale 1ns/100ps
module sim_alu4_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic [W-1:0] a, b, z;
  logic f1, f2;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  alu4_top #(.W(W)) u0 (.opnd_a(a), .opnd_b(b), .sel_logic(f1), .sel_alt(f2), .result(z));

  function automatic logic [W-1:0] model(int av, int bv, bit l, bit s);
    int r;
    case ({l, s})
      2'b00: r = (av + bv) % 256;
      2'b01: r = (av - bv + 256) % 256;
      2'b10: r = av & bv;
      default: r = av | bv;
    endcase
    return r[W-1:0];
  endfunction

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic check(string req, logic [W-1:0] exp);
    checks++;
    if ($isunknown(z) || z !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d f=%b%b actual=%b expected=%b", req, a, b, f1, f2, z, exp);
    end
  endtask

  // drive half a unit after an edge, sample one unit later: never on an edge
  task automatic apply(int av, int bv, bit l, bit s, string req);
    a = av[W-1:0]; b = bv[W-1:0]; f1 = l; f2 = s;
    #1;
    check(req, model(av, bv, l, s));
    #1;
  endtask

  initial begin
    #(700us);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    a = '0; b = '0; f1 = 1'b0; f2 = 1'b0;
    #0.5;
    // initial all-zero state
    #1; checks++;
    if (z !== 8'd0) begin fails++; $display("FAIL R6 initial actual=%b expected=00000000", z); end
    #1;
    // R7 documented vectors
    apply(146, 58, 0, 0, "R7");
    check("R7", 8'd204);
    apply(146, 58, 0, 1, "R7");
    apply(146, 58, 1, 0, "R7");
    apply(146, 58, 1, 1, "R7");
    // R5 wrap, carry discarded
    apply(127, 127, 0, 0, "R5");
    apply(255, 1, 0, 0, "R5");
    apply(255, 255, 0, 0, "R5");
    // R2 borrow chains
    apply(126, 127, 0, 1, "R2");
    apply(0, 1, 0, 1, "R2");
    apply(127, 127, 0, 1, "R2");
    apply(0, 0, 0, 1, "R2");
    // R3 / R4 extremes
    apply(127, 127, 1, 0, "R3");
    apply(255, 0, 1, 0, "R3");
    apply(127, 127, 1, 1, "R4");
    apply(0, 0, 1, 1, "R4");
    // exhaustive sweep: R1 R2 R3 R4 R6
    for (int fc = 0; fc < 4; fc++)
      for (int av = 0; av < 256; av++)
        for (int bv = 0; bv < 256; bv++)
          apply(av, bv, fc[1], fc[0], fc == 0 ? "R1" : fc == 1 ? "R2" : fc == 2 ? "R3" : "R4");
    // R8: seeded random history, then a fixed vector must repeat its result
    seed_dummy = $urandom(32'h1234);
    for (int k = 0; k < 2000; k++) begin
      int ra, rb, rf;
      ra = $urandom_range(255); rb = $urandom_range(255); rf = $urandom_range(3);
      apply(ra, rb, rf[1], rf[0], "R8");
      if (k % 100 == 0) apply(200, 77, 0, 1, "R8");
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule